// File: doc/BRIEF.md
# Real-Time Clock with Posted Register Writes

This block is a real-time clock that sits on an APB bus. It keeps a sub-second count and a seconds count, compares each one against its own alarm value, and holds two interrupt flags behind a single interrupt line. The counting side advances on a slow time-base strobe, `rtc_tick`, which is one cycle wide and synchronous to the bus clock. Each strobe stands for one edge of the slow RTC clock.

A bus write is not applied when the bus cycle ends. The write is posted: it is captured into a slot for its target and lands in the register on the third time-base strobe after acceptance. Software can see each slot through a busy flag in the status word. If software writes again to a target whose slot is still busy, that write is thrown away and a sticky error flag is set. The bus always completes in two cycles with no wait states. Read data is the completed register contents.

Top module: `rtc_posted_apb`

## Requirements
- R1: Word registers are decoded from paddr[4:2]:
  - 0 is the sub-second counter (15 bits).
  - 1 is the seconds counter (32 bits).
  - 2 is the sub-second alarm.
  - 3 is the seconds alarm.
  - 4 is control (4 bits).
  - 5 is status.
  - 6 is interrupt clear.
  - Reads of 6 and 7 return zero. Unused bits read as zero. pready is always 1.
- R2: Control bit 0 lets the sub-second counter advance on each strobe. Control bit 1 lets the seconds counter advance. A counter whose enable bit is 0 keeps its value.
- R3: The sub-second counter goes from 32767 to 0. That wrap adds one to the seconds counter when control bit 1 is set. The seconds counter rolls from 0xFFFFFFFF to 0.
- R4: Status bit 0 latches when the sub-second counter advances onto the sub-second alarm value. Status bit 1 latches when the seconds counter advances onto the seconds alarm value.
- R5: An accepted write lands on the third time-base strobe after the acceptance cycle. Until then its busy flag is 1. Status bits 4 to 10 are the busy flags for sub-second counter, seconds counter, sub-second alarm, seconds alarm, control, sub-second clear and seconds clear. Status bit 3 is the OR of the busy flags.
- R6: A write to a target whose slot is busy is discarded, leaving the pending value intact, and sets status bit 2.
- R7: Any bus write to the status address clears status bit 2.
- R8: Writing interrupt clear with bit 0 set posts a clear of status bit 0. Bit 1 set posts a clear of status bit 1. A clear lands with the same latency as any other write.
- R9: irq is registered. It is high one cycle after (status bit 0 AND control bit 2) OR (status bit 1 AND control bit 3) is true.
- R10: After reset every register, flag and pending slot is zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| rtc_tick | input | 1 | One-cycle strobe per slow time-base period |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1, read when 0 |
| paddr | input | 5 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, registered in the setup phase |
| pready | output | 1 | Always high, no wait states |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench drives a strobe every fourth cycle. It places the sub-second counter a few counts below its wrap, so the alarm match and the seconds carry occur inside one short window. This separates a carry taken at the wrap from one taken at the alarm.

Back-to-back writes to one target separate a discarded write from one that overwrites the pending value. A later read of that target shows which of the two values landed. The interrupt-clear register is written with each bit alone, which exposes a clear applied to the wrong flag. A load of all ones into the seconds counter, followed by a wrap, checks the modulo roll.

A behavioural model in the bench compares every output on every cycle. Latency errors of a single strobe therefore show up even where no directed read looks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // posted-write slot indices; order fixes status bit positions 4..10
  localparam int NUM_SLOTS = 7;
  localparam int SL_SUB    = 0;
  localparam int SL_SEC    = 1;
  localparam int SL_SUBALM = 2;
  localparam int SL_SECALM = 3;
  localparam int SL_CTRL   = 4;
  localparam int SL_CLRSUB = 5;
  localparam int SL_CLRSEC = 6;

  // word index (paddr[4:2]) of each register
  localparam int RA_SUB    = 0;
  localparam int RA_SEC    = 1;
  localparam int RA_SUBALM = 2;
  localparam int RA_SECALM = 3;
  localparam int RA_CTRL   = 4;
  localparam int RA_STAT   = 5;
  localparam int RA_CLR    = 6;

  // status word bit positions
  localparam int ST_SUBINT = 0;
  localparam int ST_SECINT = 1;
  localparam int ST_ERR    = 2;
  localparam int ST_ANY    = 3;
  localparam int ST_BUSY0  = 4;

  localparam int CTRL_W    = 4;
endpackage

// File: rtl/rtc_post_slot.sv
module rtc_post_slot #(
  parameter int DATA_W = 32,
  parameter int DELAY  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              accept,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              land,
  output logic [DATA_W-1:0] data
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] remain;

  assign land = busy && tick && (remain == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
      data   <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      remain <= CW'(DELAY);
      data   <= wdata;
    end else if (busy && tick) begin
      remain <= remain - CW'(1);
      if (remain == CW'(1)) busy <= 1'b0;
    end
  end

  // R5: the owner only hands an idle slot a new write
  a_r5_accept_idle: assert property (@(posedge clk) disable iff (rst)
    accept |-> !busy);
  // R5: busy rises after acceptance
  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);
  // R5: no completion without a strobe
  a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> busy);
  // R6: a pending value is never disturbed while busy
  a_r6_pending_stable: assert property (@(posedge clk) disable iff (rst)
    (busy && !accept) |=> $stable(data));
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int SUB_W   = 15,
  parameter int SUB_MAX = 32767,
  parameter int SEC_W   = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             sub_en,
  input  logic             sec_en,
  input  logic             sub_ld,
  input  logic [SUB_W-1:0] sub_ld_val,
  input  logic             sec_ld,
  input  logic [SEC_W-1:0] sec_ld_val,
  input  logic [SUB_W-1:0] sub_alarm,
  input  logic [SEC_W-1:0] sec_alarm,
  output logic [SUB_W-1:0] sub_cnt,
  output logic [SEC_W-1:0] sec_cnt,
  output logic             sub_hit,
  output logic             sec_hit
);
  logic             sub_step, sub_wrap, sec_step;
  logic [SUB_W-1:0] sub_nxt;
  logic [SEC_W-1:0] sec_nxt;

  always_comb begin
    sub_step = tick && sub_en && !sub_ld;
    sub_wrap = sub_step && (sub_cnt == SUB_W'(SUB_MAX));
    sub_nxt  = sub_wrap ? '0 : sub_cnt + SUB_W'(1);
    sec_step = sub_wrap && sec_en && !sec_ld;
    sec_nxt  = sec_cnt + SEC_W'(1);
    sub_hit  = sub_step && (sub_nxt == sub_alarm);
    sec_hit  = sec_step && (sec_nxt == sec_alarm);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_cnt <= '0;
      sec_cnt <= '0;
    end else begin
      if (sub_ld)        sub_cnt <= sub_ld_val;
      else if (sub_step) sub_cnt <= sub_nxt;
      if (sec_ld)        sec_cnt <= sec_ld_val;
      else if (sec_step) sec_cnt <= sec_nxt;
    end
  end

  // R2: a stopped counter keeps its value
  a_r2_sub_hold: assert property (@(posedge clk) disable iff (rst)
    (!sub_en && !sub_ld) |=> $stable(sub_cnt));
  a_r2_sec_hold: assert property (@(posedge clk) disable iff (rst)
    (!sec_en && !sec_ld) |=> $stable(sec_cnt));
  // R3: wrap returns the sub-second count to zero
  a_r3_sub_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && sub_en && !sub_ld && sub_cnt == SUB_W'(SUB_MAX)) |=> (sub_cnt == '0));
  // R3: seconds only move on a wrap or a load
  a_r3_sec_moves_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (!sec_ld && !(tick && sub_cnt == SUB_W'(SUB_MAX))) |=> $stable(sec_cnt));
endmodule

// File: rtl/rtc_posted_apb.sv
module rtc_posted_apb #(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 32,
  parameter int SUB_W      = 15,
  parameter int SUB_MAX    = 32767,
  parameter int SEC_W      = 32,
  parameter int POST_DELAY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rtc_tick,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              irq
);
  import rtc_pkg::*;

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]     idx;
  logic                 bus_wr, bus_rd;
  logic [NUM_SLOTS-1:0] req, accept, busy, land;
  logic [DATA_W-1:0]    slot_data [NUM_SLOTS];
  logic                 collide;

  logic [SUB_W-1:0]  sub_alarm, sub_cnt;
  logic [SEC_W-1:0]  sec_alarm, sec_cnt;
  logic [CTRL_W-1:0] ctrl;
  logic [1:0]        int_st;
  logic              wr_err;
  logic              sub_hit, sec_hit;
  logic [DATA_W-1:0] stat_w, rd_mux;

  assign idx    = paddr[ADDR_W-1:2];
  assign bus_wr = psel && penable && pwrite;
  assign bus_rd = psel && !penable && !pwrite;
  assign pready = 1'b1;

  // ---------------- write decode into posted slots ----------------
  always_comb begin
    req            = '0;
    req[SL_SUB]    = bus_wr && (idx == IDX_W'(RA_SUB));
    req[SL_SEC]    = bus_wr && (idx == IDX_W'(RA_SEC));
    req[SL_SUBALM] = bus_wr && (idx == IDX_W'(RA_SUBALM));
    req[SL_SECALM] = bus_wr && (idx == IDX_W'(RA_SECALM));
    req[SL_CTRL]   = bus_wr && (idx == IDX_W'(RA_CTRL));
    req[SL_CLRSUB] = bus_wr && (idx == IDX_W'(RA_CLR)) && pwdata[0];
    req[SL_CLRSEC] = bus_wr && (idx == IDX_W'(RA_CLR)) && pwdata[1];
    accept         = req & ~busy;
    collide        = |(req & busy);
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    rtc_post_slot #(.DATA_W(DATA_W), .DELAY(POST_DELAY)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .tick   (rtc_tick),
      .accept (accept[g]),
      .wdata  (pwdata),
      .busy   (busy[g]),
      .land   (land[g]),
      .data   (slot_data[g])
    );
  end

  // ---------------- counters ----------------
  rtc_timebase #(.SUB_W(SUB_W), .SUB_MAX(SUB_MAX), .SEC_W(SEC_W)) u_tb (
    .clk        (clk),
    .rst        (rst),
    .tick       (rtc_tick),
    .sub_en     (ctrl[0]),
    .sec_en     (ctrl[1]),
    .sub_ld     (land[SL_SUB]),
    .sub_ld_val (slot_data[SL_SUB][SUB_W-1:0]),
    .sec_ld     (land[SL_SEC]),
    .sec_ld_val (slot_data[SL_SEC][SEC_W-1:0]),
    .sub_alarm  (sub_alarm),
    .sec_alarm  (sec_alarm),
    .sub_cnt    (sub_cnt),
    .sec_cnt    (sec_cnt),
    .sub_hit    (sub_hit),
    .sec_hit    (sec_hit)
  );

  // ---------------- completed registers and flags ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      sub_alarm <= '0;
      sec_alarm <= '0;
      ctrl      <= '0;
      int_st    <= '0;
      wr_err    <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (land[SL_SUBALM]) sub_alarm <= slot_data[SL_SUBALM][SUB_W-1:0];
      if (land[SL_SECALM]) sec_alarm <= slot_data[SL_SECALM][SEC_W-1:0];
      if (land[SL_CTRL])   ctrl      <= slot_data[SL_CTRL][CTRL_W-1:0];
      // a fresh match outranks a clear landing on the same strobe
      if (sub_hit)               int_st[0] <= 1'b1;
      else if (land[SL_CLRSUB])  int_st[0] <= 1'b0;
      if (sec_hit)               int_st[1] <= 1'b1;
      else if (land[SL_CLRSEC])  int_st[1] <= 1'b0;
      if (collide)                                wr_err <= 1'b1;
      else if (bus_wr && idx == IDX_W'(RA_STAT))  wr_err <= 1'b0;
      irq <= (int_st[0] && ctrl[2]) || (int_st[1] && ctrl[3]);
    end
  end

  // ---------------- read path, captured in the setup phase ----------------
  always_comb begin
    stat_w            = '0;
    stat_w[ST_SUBINT] = int_st[0];
    stat_w[ST_SECINT] = int_st[1];
    stat_w[ST_ERR]    = wr_err;
    stat_w[ST_ANY]    = |busy;
    stat_w[ST_BUSY0 +: NUM_SLOTS] = busy;
    rd_mux = '0;
    case (idx)
      IDX_W'(RA_SUB):    rd_mux = DATA_W'(sub_cnt);
      IDX_W'(RA_SEC):    rd_mux = DATA_W'(sec_cnt);
      IDX_W'(RA_SUBALM): rd_mux = DATA_W'(sub_alarm);
      IDX_W'(RA_SECALM): rd_mux = DATA_W'(sec_alarm);
      IDX_W'(RA_CTRL):   rd_mux = DATA_W'(ctrl);
      IDX_W'(RA_STAT):   rd_mux = stat_w;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         prdata <= '0;
    else if (bus_rd) prdata <= rd_mux;
  end

  logic unused_bits;
  assign unused_bits = ^{paddr[1:0],
                         slot_data[SL_CLRSUB], slot_data[SL_CLRSEC],
                         slot_data[SL_SUB][DATA_W-1:SUB_W],
                         slot_data[SL_SUBALM][DATA_W-1:SUB_W],
                         slot_data[SL_CTRL][DATA_W-1:CTRL_W]};

  // R6: a write onto a busy target raises the error flag
  a_r6_collision_error: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && |(req & busy)) |=> wr_err);
  // R7: a status write clears the error flag
  a_r7_status_clears: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && idx == IDX_W'(RA_STAT)) |=> !wr_err);
  // R4: an alarm match leaves its flag set
  a_r4_sub_latch: assert property (@(posedge clk) disable iff (rst)
    sub_hit |=> int_st[0]);
  a_r4_sec_latch: assert property (@(posedge clk) disable iff (rst)
    sec_hit |=> int_st[1]);
  // R9: irq needs an enabled source in the cycle before
  a_r9_irq_enabled: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(ctrl[3:2]) != 2'b00));
  // R1: no wait states
  a_r1_ready: assert property (@(posedge clk) disable iff (rst) pready);
endmodule

// File: tb/rtc_posted_apb_test.sv
module rtc_posted_apb_test;
  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rtc_tick = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [4:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, irq;

  rtc_posted_apb uut (
    .clk(clk), .rst(rst), .rtc_tick(rtc_tick), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    vectors = 0;
  int    fails   = 0;
  int    tick_div = 0;
  int    tick_ctr = 0;
  string cur_req = "R10";
  bit    finished = 0;

  // ---------------- behavioural reference model ----------------
  int          m_sub, m_salm, m_ctrl, m_left [7];
  logic [31:0] m_sec, m_calm, m_pv [7], m_prdata;
  bit          m_int0, m_int1, m_err, m_irq;

  function automatic logic [31:0] model_read(input logic [4:0] a);
    logic [31:0] s;
    s = '0;
    case (a[4:2])
      3'd0: return 32'(m_sub);
      3'd1: return m_sec;
      3'd2: return 32'(m_salm);
      3'd3: return m_calm;
      3'd4: return 32'(m_ctrl);
      3'd5: begin
        s[0] = m_int0; s[1] = m_int1; s[2] = m_err;
        for (int i = 0; i < 7; i++) begin
          s[4+i] = (m_left[i] > 0);
          if (m_left[i] > 0) s[3] = 1'b1;
        end
        return s;
      end
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sub = 0; m_sec = 0; m_salm = 0; m_calm = 0; m_ctrl = 0;
      m_int0 = 0; m_int1 = 0; m_err = 0; m_irq = 0; m_prdata = 0;
      for (int i = 0; i < 7; i++) begin m_left[i] = 0; m_pv[i] = 0; end
    end else begin
      bit fin [7];
      bit was_busy [7];
      bit hs, hc, new_irq;
      int n_sub;
      logic [31:0] n_sec;
      if (psel && !penable && !pwrite) m_prdata = model_read(paddr);
      new_irq = (m_int0 && m_ctrl[2]) || (m_int1 && m_ctrl[3]);
      for (int i = 0; i < 7; i++) begin
        fin[i] = rtc_tick && (m_left[i] == 1);
        was_busy[i] = (m_left[i] > 0);
      end
      hs = 0; hc = 0; n_sub = m_sub; n_sec = m_sec;
      if (fin[0]) n_sub = int'(m_pv[0][14:0]);
      else if (rtc_tick && m_ctrl[0]) begin
        if (m_sub == 32767) begin
          n_sub = 0;
          if (m_ctrl[1] && !fin[1]) begin
            n_sec = m_sec + 1;
            hc = (n_sec == m_calm);
          end
        end else n_sub = m_sub + 1;
        hs = (n_sub == m_salm);
      end
      if (fin[1]) n_sec = m_pv[1];
      if (fin[2]) m_salm = int'(m_pv[2][14:0]);
      if (fin[3]) m_calm = m_pv[3];
      if (fin[4]) m_ctrl = int'(m_pv[4][3:0]);
      if (hs) m_int0 = 1; else if (fin[5]) m_int0 = 0;
      if (hc) m_int1 = 1; else if (fin[6]) m_int1 = 0;
      m_sub = n_sub; m_sec = n_sec;
      for (int i = 0; i < 7; i++)
        if (rtc_tick && m_left[i] > 0) m_left[i]--;
      if (psel && penable && pwrite) begin
        bit tgt [7];
        for (int i = 0; i < 7; i++) tgt[i] = 0;
        case (paddr[4:2])
          3'd0: tgt[0] = 1;
          3'd1: tgt[1] = 1;
          3'd2: tgt[2] = 1;
          3'd3: tgt[3] = 1;
          3'd4: tgt[4] = 1;
          3'd5: m_err = 0;
          3'd6: begin tgt[5] = pwdata[0]; tgt[6] = pwdata[1]; end
          default: ;
        endcase
        for (int i = 0; i < 7; i++) if (tgt[i]) begin
          if (was_busy[i]) m_err = 1;
          else begin m_left[i] = DLY; m_pv[i] = pwdata; end
        end
      end
      m_irq = new_irq;
    end
  end

  // ---------------- checks ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk({cur_req, " prdata"}, prdata, m_prdata);
      chk({cur_req, " irq"}, 32'(irq), 32'(m_irq));
      chk("R1 pready", 32'(pready), 32'd1);
    end
  end

  // time-base strobe
  initial forever begin
    @(negedge clk);
    tick_ctr++;
    rtc_tick = (tick_div != 0) && (tick_ctr % tick_div == 0);
  end

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1;
    @(negedge clk); d = prdata; psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    repeat (4) @(negedge clk);
    rst = 0;
    // R10: everything zero after reset
    cur_req = "R10";
    chk("R10 irq", 32'(irq), 0);
    for (int a = 0; a < 8; a++) begin
      bus_read(5'(a * 4), v);
      chk("R10 reg", v, 0);
    end
    tick_div = 4;

    // R5: posted load shows busy, lands later
    cur_req = "R5";
    bus_write(5'h00, 32'd32760);
    bus_read(5'h14, v);
    chk("R5 busy sub", v, 32'h18);
    idle(20);
    bus_read(5'h14, v);
    chk("R5 idle", v, 0);
    cur_req = "R2";
    bus_read(5'h00, v);
    chk("R2 sub held at loaded value", v, 32'd32760);

    // R6: overlapping write discarded
    cur_req = "R6";
    bus_write(5'h04, 32'd5);
    bus_write(5'h04, 32'd9);
    bus_read(5'h14, v);
    chk("R6 error plus busy", v, 32'h2C);
    idle(20);
    bus_read(5'h04, v);
    chk("R6 first value kept", v, 32'd5);
    bus_read(5'h14, v);
    chk("R6 error sticky", v, 32'h04);
    cur_req = "R7";
    bus_write(5'h14, 32'h0);
    bus_read(5'h14, v);
    chk("R7 error cleared", v, 0);

    // R3/R4/R9: alarms and carry
    cur_req = "R4";
    bus_write(5'h08, 32'd32765);
    bus_write(5'h0C, 32'd6);
    bus_write(5'h10, 32'hF);
    idle(70);
    bus_read(5'h14, v);
    chk("R4 both flags", v & 32'h3, 32'h3);
    chk("R9 irq high", 32'(irq), 1);
    cur_req = "R3";
    bus_read(5'h04, v);
    chk("R3 carry into seconds", v, 32'd6);

    // R9: disable interrupt enables
    cur_req = "R9";
    bus_write(5'h10, 32'h3);
    idle(20);
    chk("R9 irq masked", 32'(irq), 0);

    // R8: separate clears
    cur_req = "R8";
    bus_write(5'h18, 32'h1);
    idle(20);
    bus_read(5'h14, v);
    chk("R8 sub flag cleared", v & 32'h3, 32'h2);
    bus_write(5'h18, 32'h2);
    idle(20);
    bus_read(5'h14, v);
    chk("R8 sec flag cleared", v & 32'h3, 32'h0);

    // R2/R1: stop counting, unused control bits read zero
    cur_req = "R2";
    bus_write(5'h10, 32'hFFFF_FFF0);
    idle(20);
    bus_read(5'h10, v);
    chk("R1 control unused bits zero", v, 0);
    bus_read(5'h00, v);
    idle(20);
    bus_read(5'h00, v2);
    chk("R2 sub held while disabled", v2, v);

    // R3: seconds modulo roll
    cur_req = "R3";
    bus_write(5'h04, 32'hFFFF_FFFF);
    bus_write(5'h00, 32'd32767);
    bus_write(5'h10, 32'h3);
    idle(20);
    bus_read(5'h04, v);
    chk("R3 seconds roll to zero", v, 0);

    // R1: interrupt-clear and spare addresses read zero
    cur_req = "R1";
    bus_read(5'h18, v);
    chk("R1 clear reads zero", v, 0);
    bus_read(5'h1C, v);
    chk("R1 spare reads zero", v, 0);
    idle(5);
    finish_run();
  end
endmodule